// File: doc/BRIEF.md
# Nine-Line Nested Interrupt Controller

This block collects up to nine level-sensitive peripheral interrupt requests and decides which one the processor should service next. Software sets and clears each line's enable and pending state through paired write-one-to-set and write-one-to-clear registers. It gives every line a two-bit priority and can hold off all delivery with one mask bit. Requests that arrive while delivery is masked or blocked are kept as pending.

Toward the processor the block offers a request flag and the exception number of the best candidate. When the processor accepts with `cpu_take`, the chosen line goes from pending to active and is pushed on a small nesting stack. A line of strictly higher urgency can then preempt it. The `cpu_ret` strobe pops the stack, which ends the current handler and restores the exception number that was running before it. A status register shows the running exception number, the best pending exception number and an any-pending flag.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset, the enable, pending, active, priority and mask state is all zero, `cpu_req` is 0, `cpu_act` is 0 and every register reads 0.
- R2: A write to address 0 sets every enable bit whose data bit is 1. A write to address 1 clears every enable bit whose data bit is 1. Zero data bits change nothing. Both addresses read the enable bits in [8:0], and bits [31:9] read 0.
- R3: Addresses 2 and 3 set and clear pending bits with the same write-one rule, and both read the pending bits. A level input that is high at a clock edge leaves its line pending after that edge.
- R4: The priority of line n sits in register 4 + n/4, in bits [8k+7:8k+6] where k = n mod 4. Other bits of these registers, and slots with no line behind them, read 0 and ignore writes.
- R5: A line whose enable bit is 0 is never offered to the processor, but its pending bit is still recorded.
- R6: The offered line is the one with the smallest priority value among lines that are pending, enabled and not active. On a tie the lower line index wins. `cpu_vec` is 16 + n, or 0 when there is no candidate.
- R7: While bit 0 of address 7 is 1, `cpu_req` is 0 and lines keep pending. Once the bit is cleared, the best line is offered.
- R8: `cpu_take` in a cycle where `cpu_req` is 1 makes the offered line active after the edge and clears its pending bit, unless that line is re-requested in the same cycle. `cpu_take` while `cpu_req` is 0 changes nothing.
- R9: `cpu_req` is 1 only if the candidate's priority value is strictly lower than that of the innermost running handler. On preemption both lines stay active.
- R10: `cpu_ret` ends the innermost handler, and `cpu_act` returns to the exception number that was running before it, or 0. When `cpu_ret` and `cpu_take` are both high in one cycle, only the return is performed.
- R11: A request for a line that is active leaves it both active and pending, and the line is not offered again until its handler has returned.
- R12: Address 8 reads the active exception number in bits [8:0] and the offered candidate's exception number in bits [20:12]. Bit 22 is 1 when any pending bit is set, enabled or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_in | input | 9 | Level interrupt requests, one per line |
| cpu_take | input | 1 | Processor accepts the offered exception |
| cpu_ret | input | 1 | Processor returns from the innermost handler |
| cpu_req | output | 1 | An exception is offered for service |
| cpu_vec | output | 9 | Exception number offered (16 + line) or 0 |
| cpu_act | output | 9 | Exception number now running, or 0 |

## Verification
The bench builds the block with its default nine lines and two-bit priorities. That gives a four-entry nesting stack and a third priority register with only one populated slot, so the bench can read back the unpopulated slots and nest handlers two deep. At these defaults every tie-break, the strict-preemption rule and the active-and-pending case can be reached with a short, hand-picked set of priorities. Over the whole run, a behavioural model holding a queue as the nesting stack predicts the request, vector, running number and read data on every cycle.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned EXC_W    = 9;
    localparam int unsigned EXC_BASE = 16;
    localparam int unsigned PEND_LSB = 12;
    localparam int unsigned ANY_BIT  = 22;

    localparam logic [ADDR_W-1:0] ADR_EN_SET = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_EN_CLR = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_PD_SET = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_PD_CLR = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_PRIO0  = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_MASK   = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_STAT   = 4'd8;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_ctl_pkg::*;
#(
    parameter int unsigned N  = 9,
    parameter int unsigned PW = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [N-1:0]            irq_in,
    input  logic [N-1:0]            take_clr,
    output logic [N-1:0]            en_o,
    output logic [N-1:0]            pend_o,
    output logic [N-1:0][PW-1:0]    prio_o,
    output logic                    mask_o
);
    localparam int unsigned PRIO_REGS = (N + 3) / 4;

    typedef struct packed {
        logic [N-1:0]         en;
        logic [N-1:0]         pend;
        logic [N-1:0][PW-1:0] prio;
        logic                 mask;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        logic [N-1:0] en_set, en_clr, pd_set, pd_clr;
        int base;
        s_d    = s_q;
        en_set = (wr && addr == ADR_EN_SET) ? wdata[N-1:0] : '0;
        en_clr = (wr && addr == ADR_EN_CLR) ? wdata[N-1:0] : '0;
        pd_set = (wr && addr == ADR_PD_SET) ? wdata[N-1:0] : '0;
        pd_clr = (wr && addr == ADR_PD_CLR) ? wdata[N-1:0] : '0;

        s_d.en   = (s_q.en | en_set) & ~en_clr;
        s_d.pend = (s_q.pend & ~pd_clr & ~take_clr) | pd_set | irq_in;

        base = (int'(addr) - int'(ADR_PRIO0)) * 4;
        if (wr && addr >= ADR_PRIO0 && addr < ADR_PRIO0 + ADDR_W'(PRIO_REGS)) begin
            for (int j = 0; j < 4; j++) begin
                if (base + j < int'(N)) begin
                    s_d.prio[base + j] = wdata[8*j + 8 - PW +: PW];
                end
            end
        end

        if (wr && addr == ADR_MASK) begin
            s_d.mask = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o   = s_q.en;
    assign pend_o = s_q.pend;
    assign prio_o = s_q.prio;
    assign mask_o = s_q.mask;

    // R2: writing only zeros to the set-enable address leaves enables alone
    p_zero_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADR_EN_SET && wdata[N-1:0] == '0) |=> $stable(en_o));

    // R3: a line sampled high is pending after the edge
    p_level_pends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_in) |=> ((pend_o & $past(irq_in)) == $past(irq_in)));
endmodule

// File: rtl/irq_ctl_arb.sv
module irq_ctl_arb #(
    parameter int unsigned N  = 9,
    parameter int unsigned PW = 2,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 valid,
    output logic [IW-1:0]        idx,
    output logic [PW-1:0]        best_prio
);
    always_comb begin
        valid     = 1'b0;
        idx       = '0;
        best_prio = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i] && (!valid || prio[i] <= best_prio)) begin
                valid     = 1'b1;
                idx       = IW'(i);
                best_prio = prio[i];
            end
        end
    end

    // R6: the winner is always one of the candidates
    always_comb begin
        if (valid) begin
            p_pick_cand_r6: assert (cand[idx]);
        end
    end
endmodule

// File: rtl/irq_ctl_stack.sv
module irq_ctl_stack #(
    parameter int unsigned N  = 9,
    parameter int unsigned PW = 2,
    localparam int unsigned IW    = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned DEPTH = 1 << PW,
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned RW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic [PW-1:0] push_prio,
    input  logic          pop,
    output logic          top_valid,
    output logic [IW-1:0] top_idx,
    output logic [RW-1:0] run_prio,
    output logic [N-1:0]  act_o
);
    typedef struct packed {
        logic [DEPTH-1:0][IW-1:0] idx;
        logic [DEPTH-1:0][PW-1:0] pr;
        logic [CW-1:0]            cnt;
        logic [N-1:0]             act;
    } stk_t;

    stk_t s_d, s_q;
    logic [CW-1:0] tp;

    always_comb begin
        tp        = s_q.cnt - CW'(1);
        top_valid = (s_q.cnt != '0);
        top_idx   = top_valid ? s_q.idx[tp] : '0;
        run_prio  = top_valid ? {1'b0, s_q.pr[tp]} : RW'(DEPTH);
    end

    always_comb begin
        s_d = s_q;
        if (pop) begin
            if (top_valid) begin
                s_d.act[top_idx] = 1'b0;
                s_d.cnt          = s_q.cnt - CW'(1);
            end
        end else if (push) begin
            s_d.idx[s_q.cnt[CW-2:0]] = push_idx;
            s_d.pr[s_q.cnt[CW-2:0]]  = push_prio;
            s_d.act[push_idx]        = 1'b1;
            s_d.cnt                  = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_o = s_q.act;

    // R9: nesting never exceeds one level per priority value
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (s_q.cnt < CW'(DEPTH)));

    // R9: a push only happens with a strictly more urgent priority
    p_push_strict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> ({1'b0, push_prio} < run_prio));

    // R8: an accepted line is active afterwards
    p_push_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> act_o[$past(push_idx)]);

    // R10: a return deactivates the innermost line
    p_pop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && top_valid) |=> !act_o[$past(top_idx)]);

    // R9: the active set and the stack occupancy agree
    p_act_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_o) == int'(s_q.cnt));
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 9,
    parameter int unsigned PRIO_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_IRQ-1:0]  irq_in,
    input  logic                cpu_take,
    input  logic                cpu_ret,
    output logic                cpu_req,
    output logic [8:0]          cpu_vec,
    output logic [8:0]          cpu_act
);
    localparam int unsigned IW        = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int unsigned RW        = PRIO_W + 1;
    localparam int unsigned PRIO_REGS = (NUM_IRQ + 3) / 4;

    logic [NUM_IRQ-1:0]             en, pend, act, cand, take_clr;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
    logic                           mask;
    logic                           best_valid, top_valid, push;
    logic [IW-1:0]                  best_idx, top_idx;
    logic [PRIO_W-1:0]              best_prio;
    logic [RW-1:0]                  run_prio;

    irq_ctl_regs #(.N(NUM_IRQ), .PW(PRIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .irq_in(irq_in), .take_clr(take_clr),
        .en_o(en), .pend_o(pend), .prio_o(prio), .mask_o(mask)
    );

    assign cand = pend & en & ~act;

    irq_ctl_arb #(.N(NUM_IRQ), .PW(PRIO_W)) u_arb (
        .cand(cand), .prio(prio), .valid(best_valid),
        .idx(best_idx), .best_prio(best_prio)
    );

    irq_ctl_stack #(.N(NUM_IRQ), .PW(PRIO_W)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(push), .push_idx(best_idx),
        .push_prio(best_prio), .pop(cpu_ret), .top_valid(top_valid),
        .top_idx(top_idx), .run_prio(run_prio), .act_o(act)
    );

    always_comb begin
        cpu_req  = !mask && best_valid && ({1'b0, best_prio} < run_prio);
        push     = cpu_take && cpu_req && !cpu_ret;
        take_clr = '0;
        if (push) begin
            take_clr[best_idx] = 1'b1;
        end
        cpu_vec = best_valid ? 9'(EXC_BASE) + 9'(best_idx) : '0;
        cpu_act = top_valid  ? 9'(EXC_BASE) + 9'(top_idx)  : '0;
    end

    always_comb begin
        int base;
        reg_rdata = '0;
        base      = (int'(reg_addr) - int'(ADR_PRIO0)) * 4;
        if (reg_addr == ADR_EN_SET || reg_addr == ADR_EN_CLR) begin
            reg_rdata[NUM_IRQ-1:0] = en;
        end else if (reg_addr == ADR_PD_SET || reg_addr == ADR_PD_CLR) begin
            reg_rdata[NUM_IRQ-1:0] = pend;
        end else if (reg_addr == ADR_MASK) begin
            reg_rdata[0] = mask;
        end else if (reg_addr == ADR_STAT) begin
            reg_rdata[EXC_W-1:0]            = cpu_act;
            reg_rdata[PEND_LSB +: EXC_W]    = cpu_vec;
            reg_rdata[ANY_BIT]              = |pend;
        end else if (reg_addr >= ADR_PRIO0 && reg_addr < ADR_PRIO0 + 4'(PRIO_REGS)) begin
            for (int j = 0; j < 4; j++) begin
                if (base + j < int'(NUM_IRQ)) begin
                    reg_rdata[8*j + 8 - PRIO_W +: PRIO_W] = prio[base + j];
                end
            end
        end
    end

    // R5: only enabled lines are ever offered
    p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> en[best_idx]);

    // R7: a take under the mask leaves the active set unchanged
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && cpu_take && !cpu_ret) |=> $stable(act));

    // R11: a line already running is never offered again
    p_no_retake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> !act[best_idx]);
endmodule

// File: tb/sim_irq_ctl_top.sv
`timescale 1ns/1ps
module sim_irq_ctl_top;
    localparam int N = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] irq_in = '0;
    logic        cpu_take = 1'b0;
    logic        cpu_ret = 1'b0;
    logic        cpu_req;
    logic [8:0]  cpu_vec, cpu_act;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_ctl_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .cpu_take(cpu_take), .cpu_ret(cpu_ret), .cpu_req(cpu_req),
        .cpu_vec(cpu_vec), .cpu_act(cpu_act)
    );

    // ---------------- behavioural reference ----------------
    int m_en[N], m_pd[N], m_pr[N], m_act[N];
    int m_mask;
    int stk_idx[$];
    int stk_pr[$];

    task automatic m_reset();
        for (int i = 0; i < N; i++) begin
            m_en[i] = 0; m_pd[i] = 0; m_pr[i] = 0; m_act[i] = 0;
        end
        m_mask = 0;
        stk_idx.delete();
        stk_pr.delete();
    endtask

    function automatic int m_best(output int bp);
        int bi;
        bi = -1; bp = 99;
        for (int i = 0; i < N; i++) begin
            if (m_pd[i] != 0 && m_en[i] != 0 && m_act[i] == 0 && m_pr[i] < bp) begin
                bi = i; bp = m_pr[i];
            end
        end
        return bi;
    endfunction

    function automatic int m_run();
        return (stk_pr.size() > 0) ? stk_pr[$] : 4;
    endfunction

    function automatic int m_req();
        int bp, bi;
        bi = m_best(bp);
        return (m_mask == 0 && bi >= 0 && bp < m_run()) ? 1 : 0;
    endfunction

    function automatic int m_vec();
        int bp, bi;
        bi = m_best(bp);
        return (bi >= 0) ? 16 + bi : 0;
    endfunction

    function automatic int m_actnum();
        return (stk_idx.size() > 0) ? 16 + stk_idx[$] : 0;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] r;
        int anyp;
        r = '0;
        anyp = 0;
        case (a)
            0, 1: for (int i = 0; i < N; i++) r[i] = (m_en[i] != 0);
            2, 3: for (int i = 0; i < N; i++) r[i] = (m_pd[i] != 0);
            4, 5, 6: for (int j = 0; j < 4; j++)
                if ((a - 4) * 4 + j < N) r[8*j+6 +: 2] = 2'(m_pr[(a - 4) * 4 + j]);
            7: r[0] = (m_mask != 0);
            8: begin
                for (int i = 0; i < N; i++) if (m_pd[i] != 0) anyp = 1;
                r[8:0]   = 9'(m_actnum());
                r[20:12] = 9'(m_vec());
                r[22]    = (anyp != 0);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic m_step();
        int bp, bi, req, tk;
        bi  = m_best(bp);
        req = m_req();
        tk  = -1;
        if (cpu_ret) begin
            if (stk_idx.size() > 0) begin
                m_act[stk_idx[$]] = 0;
                void'(stk_idx.pop_back());
                void'(stk_pr.pop_back());
            end
        end else if (cpu_take && req != 0) begin
            stk_idx.push_back(bi);
            stk_pr.push_back(bp);
            m_act[bi] = 1;
            tk = bi;
        end
        for (int i = 0; i < N; i++) begin
            int ps, pc, es, ec;
            ps = (reg_wr && reg_addr == 2 && reg_wdata[i]) ? 1 : 0;
            pc = (reg_wr && reg_addr == 3 && reg_wdata[i]) ? 1 : 0;
            es = (reg_wr && reg_addr == 0 && reg_wdata[i]) ? 1 : 0;
            ec = (reg_wr && reg_addr == 1 && reg_wdata[i]) ? 1 : 0;
            m_pd[i] = ((m_pd[i] != 0 && pc == 0 && i != tk) || irq_in[i] || ps != 0) ? 1 : 0;
            m_en[i] = ((m_en[i] != 0 || es != 0) && ec == 0) ? 1 : 0;
        end
        if (reg_wr && reg_addr >= 4 && reg_addr <= 6) begin
            for (int j = 0; j < 4; j++)
                if ((int'(reg_addr) - 4) * 4 + j < N)
                    m_pr[(int'(reg_addr) - 4) * 4 + j] = int'(reg_wdata[8*j+6 +: 2]);
        end
        if (reg_wr && reg_addr == 7) m_mask = int'(reg_wdata[0]);
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else m_step();
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, 5 ns after each edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R9 cpu_req vs model", 32'(cpu_req), 32'(m_req()));
            chk("R6 cpu_vec vs model", 32'(cpu_vec), 32'(m_vec()));
            chk("R10 cpu_act vs model", 32'(cpu_act), 32'(m_actnum()));
            chk("R12 reg_rdata vs model", reg_rdata, m_read(int'(reg_addr)));
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_irq(int line);
        @(negedge clk);
        irq_in[line] = 1'b1;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic pulse_take();
        @(negedge clk);
        cpu_take = 1'b1;
        @(negedge clk);
        cpu_take = 1'b0;
    endtask

    task automatic pulse_ret();
        @(negedge clk);
        cpu_ret = 1'b1;
        @(negedge clk);
        cpu_ret = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd8, 32'h0, "R1 status after reset");
        rd(4'd0, 32'h0, "R1 enable after reset");
        chk("R1 cpu_req after reset", 32'(cpu_req), 32'h0);
        // R2 enable pair
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, 32'h0000_01FF, "R2 set-enable all ones");
        wr(4'd1, 32'h0);
        rd(4'd1, 32'h0000_01FF, "R2 clear-enable zero write");
        wr(4'd1, 32'h8);
        rd(4'd0, 32'h0000_01F7, "R2 clear-enable line 3");
        // R4 priority registers
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, 32'hC0C0_C0C0, "R4 priority reserved bits");
        wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd6, 32'h0000_00C0, "R4 partial last register");
        wr(4'd6, 32'h0);
        wr(4'd4, 32'h4080_80C0);
        rd(4'd4, 32'h4080_80C0, "R4 priority readback");
        // R7 mask holds delivery
        wr(4'd7, 32'h1);
        rd(4'd7, 32'h1, "R7 mask readback");
        wr(4'd2, 32'h6);
        chk("R7 no request while masked", 32'(cpu_req), 32'h0);
        rd(4'd8, 32'h0041_1000, "R12 status pending field");
        wr(4'd7, 32'h0);
        chk("R7 request after unmask", 32'(cpu_req), 32'h1);
        chk("R6 tie goes to lower line", 32'(cpu_vec), 32'd17);
        // R5 disabled line pends but is not offered
        pulse_irq(3);
        rd(4'd2, 32'h0000_000E, "R3 level input sets pending");
        chk("R5 disabled line not offered", 32'(cpu_vec), 32'd17);
        // R8 take
        pulse_take();
        rd(4'd8, 32'h0041_2011, "R8 active after take");
        rd(4'd2, 32'h0000_000C, "R8 pending cleared on take");
        chk("R9 equal priority does not preempt", 32'(cpu_req), 32'h0);
        // R9 preemption
        wr(4'd0, 32'h8);
        chk("R9 higher priority offered", 32'(cpu_vec), 32'd19);
        chk("R9 higher priority request", 32'(cpu_req), 32'h1);
        pulse_take();
        rd(4'd8, 32'h0041_2013, "R9 nested active");
        // R11 active and pending
        pulse_irq(3);
        rd(4'd2, 32'h0000_000C, "R11 active line re-pends");
        chk("R11 active line not re-offered", 32'(cpu_req), 32'h0);
        // R10 returns
        pulse_ret();
        rd(4'd8, 32'h0041_3011, "R10 restored outer handler");
        chk("R10 pending line offered after return", 32'(cpu_vec), 32'd19);
        pulse_take();
        pulse_ret();
        chk("R10 back to outer", 32'(cpu_act), 32'd17);
        pulse_ret();
        rd(4'd8, 32'h0041_2000, "R10 thread level after last return");
        // R8 take without request is ignored
        wr(4'd7, 32'h1);
        pulse_take();
        rd(4'd8, 32'h0041_2000, "R8 take ignored when no request");
        wr(4'd7, 32'h0);
        // R10 simultaneous take and return: return only
        @(negedge clk);
        cpu_take = 1'b1; cpu_ret = 1'b1;
        @(negedge clk);
        cpu_take = 1'b0; cpu_ret = 1'b0;
        chk("R10 take dropped with return", 32'(cpu_act), 32'h0);
        // R3 clear pending
        wr(4'd3, 32'h4);
        rd(4'd2, 32'h0, "R3 clear-pending");
        rd(4'd8, 32'h0, "R12 status idle");
        chk("R3 no request after clear", 32'(cpu_req), 32'h0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule